// File: doc/BRIEF.md
# NAND Controller Interrupt and ECC Status Unit

This unit gathers single-cycle event indications from a NAND flash controller into one interrupt status word and drives one registered interrupt line. The event sources are the command sequencer (sequence finished, data word ready), the DMA engine (transfer finished) and, for each chip select, a memory-ready event, a status-error event and an ECC-result event. A mask word selects which sources may record a flag. A global enable bit gates the recording of new flags. It does not gate the output, so a flag that is already pending keeps the line asserted.

The unit also tracks ECC results for each chip select. When the ECC decoder reports a result for a chip select, the three flags for that chip select are replaced: correctable, uncorrectable, and over-threshold. The over-threshold flag is raised when the count of corrected bits is strictly greater than a programmed 6-bit limit. The count from the most recent result is also kept. Software reaches all of this through a simple word-addressed read/write port. Read data returns one cycle after the request.

Register words, selected by `addr_i`: 0 = control (bit 0 global enable), 1 = interrupt mask, 2 = interrupt status, 3 = ECC threshold (bits 5:0), 4 = ECC flags (read only), 5 = last correction count (read only).

Top module: `nfc_irq_ecc_unit`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: An interrupt status bit is set by the 0-to-1 transition of its source, provided its mask bit and the global enable are both 1. The bit is visible in a read issued the cycle after the transition. A source held high does not set the bit again after it has been cleared.
- R3: A source whose mask bit is 0, or any source while the global enable is 0, leaves the status word unchanged.
- R4: Status and mask bit positions are as follows. Sequence finished is bit 1, data word ready is bit 2 and DMA finished is bit 3. For chip select cs, memory ready is bit 8+cs, status error is bit 16+cs and ECC result is bit 24+cs.
- R5: A write to the status word keeps only the bits written as 1 (status becomes status AND wdata). Writing 0 therefore clears every pending flag.
- R6: A source transition in the same cycle as a clearing status write wins, so that bit reads 1 afterwards.
- R7: `irq_o` is a registered OR of the status bits whose mask bit is 1, one cycle behind the status word. Clearing a mask bit removes that bit's contribution. Clearing the global enable does not deassert a pending interrupt.
- R8: An ECC result for chip select cs replaces that chip select's flags in the ECC flag word. The correctable flag (bit cs) is set when the count is nonzero and the result is not uncorrectable. The uncorrectable flag is bit 8+cs. Flags of other chip selects are unchanged.
- R9: The over-threshold flag (bit 16+cs of the ECC flag word) is set exactly when the result's correction count is strictly greater than the threshold held in bits 5:0 of word 3.
- R10: Word 5 holds the correction count of the most recent ECC result.
- R11: `rvalid_o` and `rdata_o` follow a read request by one cycle. Unused words read 0. Mask bits that belong to no source read 0. Writes to words 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| ev_cmd_end_i | input | 1 | Sequencer finished a command |
| ev_data_rdy_i | input | 1 | Sequencer has a data word ready |
| ev_dma_done_i | input | 1 | DMA transfer finished |
| ev_mem_rdy_i | input | NUM_CS | Memory ready event per chip select |
| ev_stat_err_i | input | NUM_CS | Status error event per chip select |
| ecc_valid_i | input | 1 | ECC result strobe |
| ecc_cs_i | input | CS_W | Chip select of the ECC result |
| ecc_count_i | input | CNT_W | Corrected bit count of the result |
| ecc_uncorr_i | input | 1 | Result is uncorrectable |
| irq_o | output | 1 | Interrupt request |

## Verification
A source transition that is presented before a clock edge is recorded in the status word at that edge. It is therefore seen by a read issued in the next cycle, and `irq_o` reflects it one edge after the status change. ECC flags and the count update at the edge of the result strobe, so they are also readable from the next cycle. Every read pushes its expected word into a queue together with its requirement tag. A monitor pops that entry at the falling edge at which `rvalid_o` is high, which is one cycle after the request. Interrupt checks are sampled at a falling edge that lies two edges after the stimulus, so both register stages have settled.

// File: rtl/nfc_irq_pkg.sv
package nfc_irq_pkg;

    localparam int REG_DW    = 32;
    localparam int REG_AW    = 3;
    localparam int MAX_CS    = 8;

    localparam int BIT_CMD_END  = 1;
    localparam int BIT_DATA_RDY = 2;
    localparam int BIT_DMA_DONE = 3;
    localparam int BASE_MEM_RDY = 8;
    localparam int BASE_STS_ERR = 16;
    localparam int BASE_ECC_EVT = 24;

    localparam int ECC_CORR_BASE = 0;
    localparam int ECC_UNC_BASE  = 8;
    localparam int ECC_OVER_BASE = 16;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_MASK  = 3'd1,
        RA_STAT  = 3'd2,
        RA_THR   = 3'd3,
        RA_ECC   = 3'd4,
        RA_LEVEL = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic corr;
        logic unc;
        logic over;
    } ecc_flags_t;

    function automatic logic [REG_DW-1:0] impl_bits(input int ncs);
        logic [REG_DW-1:0] m;
        m = '0;
        m[BIT_CMD_END]  = 1'b1;
        m[BIT_DATA_RDY] = 1'b1;
        m[BIT_DMA_DONE] = 1'b1;
        for (int i = 0; i < ncs; i++) begin
            m[BASE_MEM_RDY + i] = 1'b1;
            m[BASE_STS_ERR + i] = 1'b1;
            m[BASE_ECC_EVT + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nfc_evt_edge.sv
module nfc_evt_edge #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= raw_i;
    end

    assign rise_o = raw_i & ~prev_q;
endmodule

// File: rtl/nfc_irq_core.sv
module nfc_irq_core #(
    parameter int                W     = 32,
    parameter logic [W-1:0]      VALID = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] rise_i,
    input  logic         gen_en_i,
    input  logic         wr_mask_i,
    input  logic         wr_stat_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] stat_q, mask_q, set_v, keep_v;
    logic         irq_q;

    always_comb begin
        set_v  = rise_i & mask_q & {W{gen_en_i}};
        keep_v = wr_stat_i ? (stat_q & wdata_i) : stat_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (keep_v | set_v) & VALID;
            if (wr_mask_i) mask_q <= wdata_i & VALID;
            irq_q  <= |(stat_q & mask_q);
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/nfc_ecc_track.sv
module nfc_ecc_track
    import nfc_irq_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CS_W   = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [CS_W-1:0]   cs_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              unc_i,
    input  logic [CNT_W-1:0]  thr_i,
    output logic [NUM_CS-1:0] corr_o,
    output logic [NUM_CS-1:0] unc_o,
    output logic [NUM_CS-1:0] over_o,
    output logic [CNT_W-1:0]  level_o
);
    ecc_flags_t   next_f;
    logic         cs_ok;
    logic [CNT_W-1:0] level_q;

    always_comb begin
        next_f.corr = (count_i != '0) && !unc_i;
        next_f.unc  = unc_i;
        next_f.over = count_i > thr_i;
        cs_ok       = {1'b0, cs_i} < (CS_W+1)'(NUM_CS);
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        ecc_flags_t flags_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)                                flags_q <= '0;
            else if (valid_i && cs_i == CS_W'(g))     flags_q <= next_f;
        end
        assign corr_o[g] = flags_q.corr;
        assign unc_o[g]  = flags_q.unc;
        assign over_o[g] = flags_q.over;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                level_q <= '0;
        else if (valid_i && cs_ok) level_q <= count_i;
    end

    assign level_o = level_q;
endmodule

// File: rtl/nfc_irq_ecc_unit.sv
module nfc_irq_ecc_unit
    import nfc_irq_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CNT_W  = 6,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [2:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               rvalid_o,
    input  logic               ev_cmd_end_i,
    input  logic               ev_data_rdy_i,
    input  logic               ev_dma_done_i,
    input  logic [NUM_CS-1:0]  ev_mem_rdy_i,
    input  logic [NUM_CS-1:0]  ev_stat_err_i,
    input  logic               ecc_valid_i,
    input  logic [CS_W-1:0]    ecc_cs_i,
    input  logic [CNT_W-1:0]   ecc_count_i,
    input  logic               ecc_uncorr_i,
    output logic               irq_o
);
    localparam logic [REG_DW-1:0] VALID_BITS = impl_bits(NUM_CS);

    logic [REG_DW-1:0] raw_v, rise_v, stat_v, mask_v, ecc_word;
    logic              gen_q;
    logic [CNT_W-1:0]  thr_q, level_v;
    logic [NUM_CS-1:0] corr_v, unc_v, over_v;
    logic              wr_mask, wr_stat;
    reg_addr_e         ra;

    assign ra      = reg_addr_e'(addr_i);
    assign wr_mask = wr_en_i && ra == RA_MASK;
    assign wr_stat = wr_en_i && ra == RA_STAT;

    always_comb begin
        raw_v = '0;
        raw_v[BIT_CMD_END]  = ev_cmd_end_i;
        raw_v[BIT_DATA_RDY] = ev_data_rdy_i;
        raw_v[BIT_DMA_DONE] = ev_dma_done_i;
        for (int i = 0; i < NUM_CS; i++) begin
            raw_v[BASE_MEM_RDY + i] = ev_mem_rdy_i[i];
            raw_v[BASE_STS_ERR + i] = ev_stat_err_i[i];
            raw_v[BASE_ECC_EVT + i] = ecc_valid_i && (ecc_cs_i == CS_W'(i));
        end
    end

    nfc_evt_edge #(.W(REG_DW)) edge_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .raw_i (raw_v),
        .rise_o(rise_v)
    );

    nfc_irq_core #(.W(REG_DW), .VALID(VALID_BITS)) core_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rise_i   (rise_v),
        .gen_en_i (gen_q),
        .wr_mask_i(wr_mask),
        .wr_stat_i(wr_stat),
        .wdata_i  (wdata_i),
        .stat_o   (stat_v),
        .mask_o   (mask_v),
        .irq_o    (irq_o)
    );

    nfc_ecc_track #(.NUM_CS(NUM_CS), .CS_W(CS_W), .CNT_W(CNT_W)) ecc_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .valid_i(ecc_valid_i),
        .cs_i   (ecc_cs_i),
        .count_i(ecc_count_i),
        .unc_i  (ecc_uncorr_i),
        .thr_i  (thr_q),
        .corr_o (corr_v),
        .unc_o  (unc_v),
        .over_o (over_v),
        .level_o(level_v)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gen_q <= 1'b0;
            thr_q <= '0;
        end else if (wr_en_i) begin
            if (ra == RA_CTRL) gen_q <= wdata_i[0];
            if (ra == RA_THR)  thr_q <= wdata_i[CNT_W-1:0];
        end
    end

    always_comb begin
        ecc_word = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            ecc_word[ECC_CORR_BASE + i] = corr_v[i];
            ecc_word[ECC_UNC_BASE + i]  = unc_v[i];
            ecc_word[ECC_OVER_BASE + i] = over_v[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en_i;
            if (rd_en_i) begin
                case (ra)
                    RA_CTRL:  rdata_o <= {31'b0, gen_q};
                    RA_MASK:  rdata_o <= mask_v;
                    RA_STAT:  rdata_o <= stat_v;
                    RA_THR:   rdata_o <= {{(REG_DW-CNT_W){1'b0}}, thr_q};
                    RA_ECC:   rdata_o <= ecc_word;
                    RA_LEVEL: rdata_o <= {{(REG_DW-CNT_W){1'b0}}, level_v};
                    default:  rdata_o <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/nfc_irq_ecc_unit_chk.sv
module nfc_irq_ecc_unit_chk #(
    parameter int NUM_CS = 8,
    parameter int CNT_W  = 6,
    parameter int CS_W   = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              irq_o,
    input logic [31:0]       stat_v,
    input logic [31:0]       mask_v,
    input logic [31:0]       rise_v,
    input logic              gen_q,
    input logic              wr_en_i,
    input logic [2:0]        addr_i,
    input logic [31:0]       wdata_i,
    input logic              ecc_valid_i,
    input logic [CS_W-1:0]   ecc_cs_i,
    input logic [CNT_W-1:0]  ecc_count_i,
    input logic              ecc_uncorr_i,
    input logic [CNT_W-1:0]  thr_q,
    input logic [NUM_CS-1:0] unc_v,
    input logic [NUM_CS-1:0] over_v,
    input logic [CNT_W-1:0]  level_v
);
    logic cs_in_range;
    assign cs_in_range = {1'b0, ecc_cs_i} < (CS_W+1)'(NUM_CS);

    // R1
    a_r1_irq_low_after_reset: assert property (@(posedge clk_i)
        rst_i |=> !irq_o);

    // R3
    a_r3_new_bits_enabled: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((stat_v & ~$past(stat_v) & ~$past(mask_v)) == 32'b0));

    a_r3_gen_off_no_new_bits: assert property (@(posedge clk_i) disable iff (rst_i)
        !gen_q |=> ((stat_v & ~$past(stat_v)) == 32'b0));

    // R5
    a_r5_zero_write_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == 3'd2 && wdata_i == 32'b0 && rise_v == 32'b0) |=> stat_v == 32'b0);

    // R6
    a_r6_event_beats_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == 3'd2 && rise_v[1] && mask_v[1] && gen_q) |=> stat_v[1]);

    // R7
    a_r7_no_pending_no_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        ((stat_v & mask_v) == 32'b0) |=> !irq_o);

    // R8
    a_r8_unc_replaced: assert property (@(posedge clk_i) disable iff (rst_i)
        (ecc_valid_i && cs_in_range) |=> unc_v[$past(ecc_cs_i)] == $past(ecc_uncorr_i));

    // R9
    a_r9_over_vs_threshold: assert property (@(posedge clk_i) disable iff (rst_i)
        (ecc_valid_i && cs_in_range) |=> over_v[$past(ecc_cs_i)] == ($past(ecc_count_i) > $past(thr_q)));

    // R10
    a_r10_level_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (ecc_valid_i && cs_in_range) |=> level_v == $past(ecc_count_i));
endmodule

bind nfc_irq_ecc_unit nfc_irq_ecc_unit_chk #(
    .NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .irq_o       (irq_o),
    .stat_v      (stat_v),
    .mask_v      (mask_v),
    .rise_v      (rise_v),
    .gen_q       (gen_q),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ecc_valid_i (ecc_valid_i),
    .ecc_cs_i    (ecc_cs_i),
    .ecc_count_i (ecc_count_i),
    .ecc_uncorr_i(ecc_uncorr_i),
    .thr_q       (thr_q),
    .unc_v       (unc_v),
    .over_v      (over_v),
    .level_v     (level_v)
);

// File: tb/nfc_irq_ecc_unit_tb_top.sv
module nfc_irq_ecc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCS  = 8;
    localparam int CNTW = 6;
    localparam int CSW  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            rvalid;
    logic            ev_cmd = 1'b0, ev_drdy = 1'b0, ev_dma = 1'b0;
    logic [NCS-1:0]  ev_mem = '0, ev_serr = '0;
    logic            ecc_v = 1'b0;
    logic [CSW-1:0]  ecc_cs = '0;
    logic [CNTW-1:0] ecc_cnt = '0;
    logic            ecc_unc = 1'b0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nfc_irq_ecc_unit #(.NUM_CS(NCS), .CNT_W(CNTW)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .ev_cmd_end_i(ev_cmd), .ev_data_rdy_i(ev_drdy), .ev_dma_done_i(ev_dma),
        .ev_mem_rdy_i(ev_mem), .ev_stat_err_i(ev_serr),
        .ecc_valid_i(ecc_v), .ecc_cs_i(ecc_cs), .ecc_count_i(ecc_cnt),
        .ecc_uncorr_i(ecc_unc), .irq_o(irq)
    );

    // monitor: pops one expected word per returned read
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected read data actual=%h expected=none", "R11", rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic ecc_res(input int cs, input int cnt, input logic unc);
        ecc_v = 1'b1; ecc_cs = CSW'(cs); ecc_cnt = CNTW'(cnt); ecc_unc = unc;
        tick();
        ecc_v = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end actual=timeout expected=done");
        summary();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_irq(1'b0, "R1");
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1");

        // R11 mask keeps only implemented bits
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'hFFFF_FF0E, "R11");

        // R3 global enable off: event ignored
        ev_cmd = 1'b1; tick(); ev_cmd = 1'b0;
        rd(3'd2, 32'h0, "R3");
        chk_irq(1'b0, "R3");

        // R2 R4 sequence finished sets bit 1
        wr(3'd0, 32'h1);
        rd(3'd0, 32'h1, "R11");
        ev_cmd = 1'b1; tick(); ev_cmd = 1'b0;
        rd(3'd2, 32'h0000_0002, "R2");
        chk_irq(1'b1, "R7");

        // R4 positions of the remaining sources
        ev_drdy = 1'b1; ev_dma = 1'b1; ev_mem[3] = 1'b1; ev_serr[5] = 1'b1;
        tick();
        ev_drdy = 1'b0; ev_dma = 1'b0; ev_mem = '0; ev_serr = '0;
        rd(3'd2, 32'h0020_080E, "R4");

        // R7 clearing global enable keeps irq
        wr(3'd0, 32'h0);
        tick();
        chk_irq(1'b1, "R7");
        wr(3'd0, 32'h1);

        // R5 write zero clears all
        wr(3'd2, 32'h0);
        rd(3'd2, 32'h0, "R5");
        chk_irq(1'b0, "R5");

        // R5 partial keep
        ev_cmd = 1'b1; ev_dma = 1'b1; tick(); ev_cmd = 1'b0; ev_dma = 1'b0;
        wr(3'd2, 32'h0000_0008);
        rd(3'd2, 32'h0000_0008, "R5");

        // R6 event in the same cycle as clear wins
        ev_cmd = 1'b1; wr(3'd2, 32'h0); ev_cmd = 1'b0;
        rd(3'd2, 32'h0000_0002, "R6");

        // R2 level held high does not re-set after clear
        ev_drdy = 1'b1; tick();
        wr(3'd2, 32'h0);
        tick(); tick();
        rd(3'd2, 32'h0, "R2");
        ev_drdy = 1'b0; tick();

        // R3 masked source ignored; R7 mask clear drops irq
        wr(3'd1, 32'hFFFF_FF06);
        ev_dma = 1'b1; tick(); ev_dma = 1'b0;
        rd(3'd2, 32'h0, "R3");
        ev_cmd = 1'b1; tick(); ev_cmd = 1'b0;
        tick();
        chk_irq(1'b1, "R7");
        wr(3'd1, 32'hFFFF_FF04);
        tick();
        chk_irq(1'b0, "R7");
        rd(3'd2, 32'h0000_0002, "R7");
        wr(3'd2, 32'h0);
        wr(3'd1, 32'hFFFF_FF0E);

        // R8 R9 R10 ECC results
        wr(3'd3, 32'h5);
        rd(3'd3, 32'h5, "R9");
        ecc_res(2, 5, 1'b0);
        rd(3'd4, 32'h0000_0004, "R9");
        rd(3'd5, 32'h5, "R10");
        rd(3'd2, 32'h0400_0000, "R4");
        ecc_res(2, 6, 1'b0);
        rd(3'd4, 32'h0004_0004, "R9");
        rd(3'd5, 32'h6, "R10");
        ecc_res(2, 0, 1'b1);
        rd(3'd4, 32'h0000_0400, "R8");
        ecc_res(7, 0, 1'b0);
        rd(3'd4, 32'h0000_0400, "R8");
        rd(3'd5, 32'h0, "R10");
        wr(3'd3, 32'h3F);
        ecc_res(1, 63, 1'b0);
        rd(3'd4, 32'h0000_0402, "R9");

        // R11 read-only words and unused words
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0000_0402, "R11");
        rd(3'd5, 32'h3F, "R11");
        rd(3'd6, 32'h0, "R11");
        rd(3'd7, 32'h0, "R11");

        tick(); tick();
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R11: missing read data actual=%0d expected=0 pending", sb_q.size());
        end
        summary();
    end
endmodule